// File: doc/BRIEF.md
# Modulation Calibration Status Tracker

This block follows the calibration run that a clock synthesizer performs whenever its frequency modulation is switched on or retuned. It watches the modulation-depth field from a control register. It also watches the completion and failure pulses from the calibration engine and a lock-detect level. From these it keeps two status flags for a register wrapper to read. The first flag, done, says whether calibration has finished since modulation was last enabled. The second flag, pass, says whether that calibration succeeded.

The pass flag is set optimistically as soon as a calibration run begins. Only a reported failure or a zero depth clears it. When done is 1 and pass is 0, the achieved modulation depth may differ from the requested one. A relock-enable gate keeps frequency-modulation relock off until calibration has completed. A new calibration request is held until the loop reports lock. A one-cycle start pulse then launches the engine.

Top module: `modcal_tracker`

## Requirements
- R1: During and right after reset, calDone, calPass, calStart and relockEn are all 0, and modulation is treated as disabled.
- R2: Modulation is enabled exactly when depthIn is nonzero. A cycle with depthIn all zeros clears calDone, calPass, any pending request and any running calibration at the next clock edge.
- R3: A cycle in which depthIn is nonzero and differs from its value in the previous cycle requests a new calibration. This covers a change from zero and a change from one nonzero value to another. calDone reads 0 from the next cycle.
- R4: calStart is high for exactly one cycle, the first cycle in which a request is pending, lockIn is 1, modulation is enabled and depthIn does not change. Without lock the request stays pending.
- R5: calPass reads 1 in the cycle after calStart.
- R6: A calFailIn pulse while calibration runs clears calPass at the next edge and does not by itself set calDone.
- R7: A calDoneIn pulse while calibration runs sets calDone at the next edge, whatever calPass is. calDone then holds until R2 or R3 clears it.
- R8: calDoneIn and calFailIn in the same cycle of a running calibration give calDone = 1 with calPass = 0.
- R9: calDoneIn and calFailIn pulses have no effect when no calibration is running. This holds while modulation is disabled, while a request waits for lock, in the start cycle itself and after calDone is set.
- R10: relockEn equals calDone AND (depthIn nonzero) in the same cycle.
- R11: If depthIn changes in the same cycle as an engine pulse, the restart wins: calDone goes to 0 and the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| depthIn | input | DEPTH_W | Modulation depth field; zero means modulation off |
| calDoneIn | input | 1 | Calibration engine completion pulse |
| calFailIn | input | 1 | Calibration engine failure pulse |
| lockIn | input | 1 | Loop lock-detect level |
| calDone | output | 1 | Status: calibration complete since last enable |
| calPass | output | 1 | Status: calibration successful |
| calStart | output | 1 | One-cycle pulse launching the calibration engine |
| relockEn | output | 1 | Permission for frequency-modulation relock |

## Verification
Two pairs of events can land in the same cycle. Completion and failure can both arrive during a run (R8). A depth change can coincide with an engine pulse (R11). The bench drives both pairs deliberately in directed steps and also lets them collide in a random phase. A behavioural model steps the same inputs and is compared with all four outputs every cycle. The expected result is a done flag with pass cleared in the first case and a clean restart with the pulse discarded in the second.

// File: rtl/modcal_pkg.sv
package modcal_pkg;
  // Strobes from control to datapath flags
  typedef struct packed {
    logic setPass;
    logic clrPass;
    logic setDone;
    logic clrDone;
  } flagStrobes_t;
endpackage

// File: rtl/modcal_dp.sv
module modcal_dp
  import modcal_pkg::*;
#(
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DEPTH_W-1:0] depthIn,
  input  flagStrobes_t       strb,
  output logic               modEn,
  output logic               depthChg,
  output logic               doneFlag,
  output logic               passFlag
);
  localparam logic [DEPTH_W-1:0] ZERO_DEPTH = '0;

  logic [DEPTH_W-1:0] depthQ;

  assign modEn    = (depthIn != ZERO_DEPTH);
  assign depthChg = modEn && (depthIn != depthQ);

  always_ff @(posedge clk) begin
    if (!rstN) depthQ <= ZERO_DEPTH;
    else       depthQ <= depthIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             doneFlag <= 1'b0;
    else if (strb.clrDone) doneFlag <= 1'b0;
    else if (strb.setDone) doneFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             passFlag <= 1'b0;
    else if (strb.clrPass) passFlag <= 1'b0;
    else if (strb.setPass) passFlag <= 1'b1;
  end
endmodule

// File: rtl/modcal_ctrl.sv
module modcal_ctrl
  import modcal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modEn,
  input  logic         depthChg,
  input  logic         engDone,
  input  logic         engFail,
  input  logic         lockIn,
  output flagStrobes_t strb,
  output logic         startPulse
);
  logic pending;
  logic busy;
  logic accept;

  assign startPulse = pending && lockIn && modEn && !depthChg;
  assign accept     = busy && modEn && !depthChg;

  always_comb begin
    strb = '0;
    if (!modEn) begin
      strb.clrDone = 1'b1;
      strb.clrPass = 1'b1;
    end else if (depthChg) begin
      strb.clrDone = 1'b1;
    end else if (startPulse) begin
      strb.setPass = 1'b1;
    end else if (accept) begin
      strb.setDone = engDone;
      strb.clrPass = engFail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      busy    <= 1'b0;
    end else if (!modEn) begin
      pending <= 1'b0;
      busy    <= 1'b0;
    end else if (depthChg) begin
      pending <= 1'b1;
      busy    <= 1'b0;
    end else if (startPulse) begin
      pending <= 1'b0;
      busy    <= 1'b1;
    end else if (accept && engDone) begin
      busy    <= 1'b0;
    end
  end
endmodule

// File: rtl/modcal_tracker.sv
module modcal_tracker
  import modcal_pkg::*;
#(
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DEPTH_W-1:0] depthIn,
  input  logic               calDoneIn,
  input  logic               calFailIn,
  input  logic               lockIn,
  output logic               calDone,
  output logic               calPass,
  output logic               calStart,
  output logic               relockEn
);
  flagStrobes_t strb;
  logic modEn;
  logic depthChg;

  modcal_dp #(.DEPTH_W(DEPTH_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .depthIn  (depthIn),
    .strb     (strb),
    .modEn    (modEn),
    .depthChg (depthChg),
    .doneFlag (calDone),
    .passFlag (calPass)
  );

  modcal_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modEn      (modEn),
    .depthChg   (depthChg),
    .engDone    (calDoneIn),
    .engFail    (calFailIn),
    .lockIn     (lockIn),
    .strb       (strb),
    .startPulse (calStart)
  );

  assign relockEn = calDone && modEn;
endmodule

// File: rtl/modcal_checker.sv
module modcal_checker #(
  parameter int DEPTH_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [DEPTH_W-1:0] depthIn,
  input logic               calDoneIn,
  input logic               lockIn,
  input logic               calDone,
  input logic               calPass,
  input logic               calStart,
  input logic               relockEn
);
  a_r2_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (depthIn == '0) |=> (!calDone && !calPass));

  a_r3_change_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    (depthIn != '0 && !$stable(depthIn)) |=> !calDone);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> !calStart);

  a_r4_start_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> lockIn);

  a_r5_pass_after_start: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> calPass);

  a_r7_done_from_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> $past(calDoneIn));

  a_r10_relock_gate: assert property (@(posedge clk) disable iff (!rstN)
    relockEn |-> (calDone && depthIn != '0));
endmodule

bind modcal_tracker modcal_checker #(.DEPTH_W(DEPTH_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .depthIn   (depthIn),
  .calDoneIn (calDoneIn),
  .lockIn    (lockIn),
  .calDone   (calDone),
  .calPass   (calPass),
  .calStart  (calStart),
  .relockEn  (relockEn)
);

// File: tb/tb_modcal_tracker.sv
module tb_modcal_tracker;
  localparam int DEPTH_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DEPTH_W-1:0] depthIn = '0;
  logic calDoneIn = 1'b0;
  logic calFailIn = 1'b0;
  logic lockIn = 1'b0;
  logic calDone, calPass, calStart, relockEn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int mPrev = 0;
  bit mPending = 0, mBusy = 0, mDone = 0, mPass = 0;

  always #2 clk = ~clk;  // 250 MHz

  modcal_tracker #(.DEPTH_W(DEPTH_W)) dut (
    .clk(clk), .rstN(rstN), .depthIn(depthIn), .calDoneIn(calDoneIn),
    .calFailIn(calFailIn), .lockIn(lockIn), .calDone(calDone),
    .calPass(calPass), .calStart(calStart), .relockEn(relockEn)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // drive one cycle, compare against model, then advance model at the edge
  task automatic step(input int d, input bit dn, input bit fl, input bit lk);
    bit en, chg, st;
    @(negedge clk);
    depthIn = d[DEPTH_W-1:0]; calDoneIn = dn; calFailIn = fl; lockIn = lk;
    #1;
    en  = (d != 0);
    chg = en && (d != mPrev);
    st  = mPending && lk && en && !chg;
    chk("R7 calDone", calDone, mDone);
    chk("R5 calPass", calPass, mPass);
    chk("R4 calStart", calStart, st);
    chk("R10 relockEn", relockEn, mDone && en);
    @(posedge clk);
    if (!en) begin                       // R2
      mPending = 0; mBusy = 0; mDone = 0; mPass = 0;
    end else if (chg) begin              // R3, R11
      mPending = 1; mBusy = 0; mDone = 0;
    end else if (st) begin
      mPending = 0; mBusy = 1; mPass = 1;
    end else if (mBusy) begin            // R6, R7, R8; otherwise pulses ignored (R9)
      if (dn) begin mDone = 1; mBusy = 0; end
      if (fl) mPass = 0;
    end
    mPrev = d;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 calDone", calDone, 1'b0);
    chk("R1 calPass", calPass, 1'b0);
    chk("R1 calStart", calStart, 1'b0);
    chk("R1 relockEn", relockEn, 1'b0);
    rstN = 1'b1;
    // R9: pulses while disabled are ignored
    step(0, 1, 0, 1); step(0, 0, 1, 1); step(0, 0, 0, 1);
    // R3/R4: enable without lock, request waits; pulses while pending ignored (R9)
    step(2, 0, 0, 0); step(2, 1, 0, 0); step(2, 0, 1, 0); step(2, 0, 0, 0);
    // lock arrives: start, then done pulse in start cycle ignored
    step(2, 1, 0, 1); step(2, 0, 0, 1); step(2, 0, 0, 1);
    step(2, 1, 0, 1); step(2, 0, 0, 1);
    // after done, fail is ignored (R9)
    step(2, 0, 1, 1); step(2, 0, 0, 1);
    // R3: nonzero-to-nonzero restart
    step(5, 0, 0, 1); step(5, 0, 0, 1);
    // R6: fail clears pass, done stays 0; later done sets done (R7)
    step(5, 0, 1, 1); step(5, 0, 0, 1); step(5, 1, 0, 1); step(5, 0, 0, 1);
    // R8: simultaneous done and fail
    step(3, 0, 0, 1); step(3, 0, 0, 1); step(3, 1, 1, 1); step(3, 0, 0, 1);
    // R11: depth change coincides with engine pulse
    step(6, 0, 0, 1); step(6, 0, 0, 1); step(7, 1, 0, 1); step(7, 0, 0, 1);
    step(7, 1, 0, 1); step(7, 0, 0, 1);
    // R2: depth zero clears both flags
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    // random phase to let events collide
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      step((r < 2) ? 0 : ((r < 4) ? int'($urandom_range(1, 7)) : mPrev),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 3) != 0));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule